// File: doc/BRIEF.md
# Call Stack With Carry Save

This block is the hardware return stack of a small 4-bit processor core. It holds up to four return frames. Each frame is the 12-bit program counter to resume at, plus the carry flag as it stood when the frame was saved. Subroutine calls and interrupt entry both push frames, and they share the same four slots. When a fifth frame arrives, the oldest frame is dropped so the new one can be stored.

There are two kinds of return. An interrupt return gives back the saved PC and the saved carry. A constant return gives back the saved PC but keeps the carry the core has now. It also splits an 8-bit constant fetched from program memory into a 4-bit table register and the 4-bit accumulator. The instruction decoder, program memory and ALU sit outside this block.

Every return result is registered. It appears on the outputs one cycle after the pop request, marked by a one-cycle valid pulse.

Top module: `ret_stack`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the block clears all frames and sets `depth_o` to 0. In the next cycle `pc_o`, `cy_o`, `tbr_o`, `acc_o`, `ret_valid_o`, `overflow_o` and `underflow_o` are all 0.
- R2: Frames come back last-in, first-out. A frame is 13 bits: bit 12 is the carry and bits 11:0 are the PC. One cycle after a pop, `pc_o` holds the PC of the most recent frame not yet popped.
- R3: The block holds at most 4 frames. A push without a pop while 4 frames are held drops the oldest frame and stores the new one. `depth_o` stays at 4, and `overflow_o` pulses high for one cycle after that push.
- R4: A pop with `pop_const_i` = 0 (interrupt return) sets `cy_o` to the carry bit stored in the popped frame.
- R5: A pop with `pop_const_i` = 1 (constant return) sets `cy_o` to the `cy_cur_i` value sampled with the pop. It also sets `tbr_o` to `const_i[7:4]` and `acc_o` to `const_i[3:0]`.
- R6: `tbr_o` and `acc_o` keep their values in every cycle that does not follow a constant return. `pc_o` and `cy_o` keep their values in every cycle that does not follow a pop.
- R7: A pop while no frames are held returns PC 0. For an interrupt return it also returns carry 0. `underflow_o` pulses high for one cycle, and `depth_o` stays 0.
- R8: A push and a pop in the same cycle return the current top frame and then replace it with the pushed frame; `depth_o` does not change. If the stack is empty, the pushed frame is discarded and the pop behaves as in R7.
- R9: `ret_valid_o` is high in exactly the cycles that follow a pop request.
- R10: `depth_o` always equals the number of frames held, from 0 to 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Save a return frame (call or interrupt entry) |
| push_pc_i | input | 12 | PC to save |
| push_cy_i | input | 1 | Carry to save |
| pop_i | input | 1 | Return request |
| pop_const_i | input | 1 | Return kind: 1 = constant return, 0 = interrupt return |
| const_i | input | 8 | Constant fetched from program memory for a constant return |
| cy_cur_i | input | 1 | The core's current carry flag |
| pc_o | output | 12 | Restored PC |
| cy_o | output | 1 | Carry after the return |
| tbr_o | output | 4 | Table register value |
| acc_o | output | 4 | Accumulator value |
| ret_valid_o | output | 1 | Return result is new this cycle |
| depth_o | output | 3 | Number of frames held |
| overflow_o | output | 1 | Oldest frame was dropped by the previous push |
| underflow_o | output | 1 | The previous pop found the stack empty |

## Verification
Nested pushes and pops with alternating carries show that the order is LIFO and that each frame's carry is restored with its own PC. Runs of five or six pushes separate "drop the oldest frame" from "block the push" and from "overwrite the top frame". Mixing the two return kinds while `cy_cur_i` differs from the saved carry tells the carry-restoring path from the carry-keeping path. Simultaneous push and pop, pops on an empty stack, and a long pseudo-random stream probe the replace and underflow corners against the reference model.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;

  localparam int PC_W    = 12;
  localparam int NIB_W   = 4;
  localparam int CONST_W = 2 * NIB_W;

  // Frame layout: carry in the MSB, PC below it.
  typedef struct packed {
    logic            cy;
    logic [PC_W-1:0] pc;
  } frame_t;

  localparam int FRAME_W = $bits(frame_t);

  function automatic frame_t make_frame(input logic [PC_W-1:0] pc, input logic cy);
    frame_t f;
    f.cy = cy;
    f.pc = pc;
    return f;
  endfunction

  // Upper nibble of the constant feeds the table register.
  function automatic logic [NIB_W-1:0] hi_nib(input logic [CONST_W-1:0] k);
    return k[CONST_W-1:NIB_W];
  endfunction

  // Lower nibble of the constant feeds the accumulator.
  function automatic logic [NIB_W-1:0] lo_nib(input logic [CONST_W-1:0] k);
    return k[NIB_W-1:0];
  endfunction

  // Carry after a return: kept from the core or taken from the frame.
  function automatic logic ret_carry(input logic const_ret, input logic cur, input frame_t f);
    return const_ret ? cur : f.cy;
  endfunction

endpackage

// File: rtl/ret_stack_store.sv
module ret_stack_store
  import ret_stack_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic             pop_i,
  input  frame_t           wr_frame_i,
  output frame_t           top_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] count_o,
  output logic             overflow_o,
  output logic             underflow_o
);

  frame_t           slot [DEPTH];
  logic [CNT_W-1:0] count_q;

  // Named events, also used by the assertions.
  logic ev_push, ev_pop, ev_swap, ev_drop, ev_under;
  logic is_full;

  assign empty_o  = (count_q == '0);
  assign is_full  = (count_q == CNT_W'(DEPTH));
  assign ev_push  = push_i && !pop_i;
  assign ev_pop   = pop_i && !push_i && !empty_o;
  assign ev_swap  = push_i && pop_i && !empty_o;
  assign ev_drop  = ev_push && is_full;
  assign ev_under = pop_i && empty_o;

  assign top_o   = slot[0];
  assign count_o = count_q;

  // Slot 0 is the top; higher indices are older frames.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    if (g == 0) begin : g_top
      always_ff @(posedge clk) begin
        if (rst)                     slot[g] <= '0;
        else if (ev_push || ev_swap) slot[g] <= wr_frame_i;
        else if (ev_pop)             slot[g] <= (DEPTH > 1) ? slot[(DEPTH > 1) ? 1 : 0] : '0;
      end
    end else if (g == DEPTH - 1) begin : g_bottom
      always_ff @(posedge clk) begin
        if (rst)          slot[g] <= '0;
        else if (ev_push) slot[g] <= slot[g-1];
        else if (ev_pop)  slot[g] <= '0;
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (rst)          slot[g] <= '0;
        else if (ev_push) slot[g] <= slot[g-1];
        else if (ev_pop)  slot[g] <= slot[g+1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q     <= '0;
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      overflow_o  <= ev_drop;
      underflow_o <= ev_under;
      if (ev_push && !is_full) count_q <= count_q + 1'b1;
      else if (ev_pop)         count_q <= count_q - 1'b1;
    end
  end

  // R10: occupancy stays within the depth
  a_r10_count_range: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_W'(DEPTH));

  // R3: a push into a full stack leaves it full and flags the drop
  a_r3_saturate: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i && is_full) |=> (count_q == CNT_W'(DEPTH)) && overflow_o);

  // R8: push with pop keeps the occupancy
  a_r8_replace_count: assert property (@(posedge clk) disable iff (rst)
    (push_i && pop_i) |=> $stable(count_q));

  // R7: pop on empty keeps it empty and flags it
  a_r7_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (pop_i && empty_o) |=> (count_q == '0) && underflow_o);

  // R2: a plain push puts the new frame on top
  a_r2_push_top: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i) |=> (slot[0] == $past(wr_frame_i)));

endmodule

// File: rtl/ret_stack_retout.sv
module ret_stack_retout
  import ret_stack_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               pop_i,
  input  logic               const_ret_i,
  input  logic               cy_cur_i,
  input  logic [CONST_W-1:0] const_i,
  input  frame_t             top_i,
  input  logic               empty_i,
  output logic [PC_W-1:0]    pc_o,
  output logic               cy_o,
  output logic [NIB_W-1:0]   tbr_o,
  output logic [NIB_W-1:0]   acc_o,
  output logic               valid_o
);

  frame_t src;
  logic   ld_const;

  // An empty stack yields an all-zero frame.
  assign src      = empty_i ? '0 : top_i;
  assign ld_const = pop_i && const_ret_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o    <= '0;
      cy_o    <= 1'b0;
      tbr_o   <= '0;
      acc_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= pop_i;
      if (pop_i) begin
        pc_o <= src.pc;
        cy_o <= ret_carry(const_ret_i, cy_cur_i, src);
      end
      if (ld_const) begin
        tbr_o <= hi_nib(const_i);
        acc_o <= lo_nib(const_i);
      end
    end
  end

  // R9: every pop is followed by a valid cycle
  a_r9_valid: assert property (@(posedge clk) disable iff (rst)
    pop_i |=> valid_o);

  // R5: a constant return keeps the core's carry
  a_r5_keep_carry: assert property (@(posedge clk) disable iff (rst)
    (pop_i && const_ret_i) |=> (cy_o == $past(cy_cur_i)));

  // R6: nibble registers hold outside constant returns
  a_r6_hold_nibbles: assert property (@(posedge clk) disable iff (rst)
    !(pop_i && const_ret_i) |=> ($stable(tbr_o) && $stable(acc_o)));

  // R6: pc and carry hold without a pop
  a_r6_hold_pc: assert property (@(posedge clk) disable iff (rst)
    !pop_i |=> ($stable(pc_o) && $stable(cy_o)));

endmodule

// File: rtl/ret_stack.sv
module ret_stack
  import ret_stack_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push_i,
  input  logic [PC_W-1:0]    push_pc_i,
  input  logic               push_cy_i,
  input  logic               pop_i,
  input  logic               pop_const_i,
  input  logic [CONST_W-1:0] const_i,
  input  logic               cy_cur_i,
  output logic [PC_W-1:0]    pc_o,
  output logic               cy_o,
  output logic [NIB_W-1:0]   tbr_o,
  output logic [NIB_W-1:0]   acc_o,
  output logic               ret_valid_o,
  output logic [CNT_W-1:0]   depth_o,
  output logic               overflow_o,
  output logic               underflow_o
);

  frame_t wr_frame;
  frame_t top_frame;
  logic   empty;

  assign wr_frame = make_frame(push_pc_i, push_cy_i);

  ret_stack_store #(.DEPTH(DEPTH)) u_store (
    .clk         (clk),
    .rst         (rst),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .wr_frame_i  (wr_frame),
    .top_o       (top_frame),
    .empty_o     (empty),
    .count_o     (depth_o),
    .overflow_o  (overflow_o),
    .underflow_o (underflow_o)
  );

  ret_stack_retout u_ret (
    .clk         (clk),
    .rst         (rst),
    .pop_i       (pop_i),
    .const_ret_i (pop_const_i),
    .cy_cur_i    (cy_cur_i),
    .const_i     (const_i),
    .top_i       (top_frame),
    .empty_i     (empty),
    .pc_o        (pc_o),
    .cy_o        (cy_o),
    .tbr_o       (tbr_o),
    .acc_o       (acc_o),
    .valid_o     (ret_valid_o)
  );

  // R4: an interrupt return from a non-empty stack gives the stored carry
  a_r4_restore_carry: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !pop_const_i && !empty) |=> (cy_o == $past(top_frame.cy)));

  // R7: an empty pop yields PC zero
  a_r7_zero_pc: assert property (@(posedge clk) disable iff (rst)
    (pop_i && empty) |=> (pc_o == '0));

endmodule

// File: tb/sim_ret_stack.sv
module sim_ret_stack;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_i = 1'b0;
  logic [11:0] push_pc_i = '0;
  logic        push_cy_i = 1'b0;
  logic        pop_i = 1'b0;
  logic        pop_const_i = 1'b0;
  logic [7:0]  const_i = '0;
  logic        cy_cur_i = 1'b0;
  logic [11:0] pc_o;
  logic        cy_o;
  logic [3:0]  tbr_o, acc_o;
  logic        ret_valid_o;
  logic [2:0]  depth_o;
  logic        overflow_o, underflow_o;

  always #5 clk = ~clk;

  ret_stack u0 (.*);

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // Reference model: queue front is the newest frame {cy, pc}.
  logic [12:0] q[$];
  logic [11:0] e_pc;
  logic        e_cy, e_val, e_ov, e_un;
  logic [3:0]  e_tbr, e_acc;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic [12:0] top;
    if (rst) begin
      q.delete();
      e_pc = 0; e_cy = 0; e_tbr = 0; e_acc = 0; e_val = 0; e_ov = 0; e_un = 0;
      return;
    end
    e_val = pop_i;
    e_ov  = 0;
    e_un  = 0;
    if (pop_i) begin
      if (q.size() > 0) top = q[0];
      else begin top = '0; e_un = 1; end
      e_pc = top[11:0];
      e_cy = pop_const_i ? cy_cur_i : top[12];
      if (pop_const_i) begin e_tbr = const_i[7:4]; e_acc = const_i[3:0]; end
    end
    if (push_i && pop_i) begin
      if (q.size() > 0) q[0] = {push_cy_i, push_pc_i};
    end else if (push_i) begin
      q.push_front({push_cy_i, push_pc_i});
      if (q.size() > 4) begin void'(q.pop_back()); e_ov = 1; end
    end else if (pop_i) begin
      if (q.size() > 0) void'(q.pop_front());
    end
  endtask

  task automatic compare();
    chk("R2 pc_o", pc_o, e_pc);
    chk("R4/R5 cy_o", cy_o, e_cy);
    chk("R5/R6 tbr_o", tbr_o, e_tbr);
    chk("R5/R6 acc_o", acc_o, e_acc);
    chk("R9 ret_valid_o", ret_valid_o, e_val);
    chk("R10 depth_o", depth_o, q.size());
    chk("R3 overflow_o", overflow_o, e_ov);
    chk("R7 underflow_o", underflow_o, e_un);
  endtask

  // One cycle: drive at negedge, model at posedge, compare at next negedge.
  task automatic step(input bit pu, input int pc, input bit cy, input bit po,
                      input bit kc, input int k, input bit cc);
    push_i = pu; push_pc_i = 12'(pc); push_cy_i = cy;
    pop_i = po; pop_const_i = kc; const_i = 8'(k); cy_cur_i = cc;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    @(negedge clk);
    rst = 1;
    @(posedge clk); model_edge(); @(negedge clk);
    compare();               // R1 reset state
    chk("R1 depth after reset", depth_o, 0);
    rst = 0;

    // R2/R4: nested pushes, interrupt returns, alternating carry
    step(1, 12'h111, 1, 0, 0, 0, 0);
    step(1, 12'h222, 0, 0, 0, 0, 0);
    step(1, 12'h333, 1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);
    chk("R4 stored carry", cy_o, 1);
    step(0, 0, 0, 1, 0, 0, 1);
    chk("R2 LIFO pc", pc_o, 12'h222);
    step(0, 0, 0, 1, 0, 0, 0);
    idle();

    // R3: six pushes drop the two oldest
    for (int i = 0; i < 6; i++) step(1, 12'h400 + i, i[0], 0, 0, 0, 0);
    chk("R3 saturated depth", depth_o, 4);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 0, 0, 0);
    chk("R7 underflow pc", pc_o, 0);

    // R5: constant returns keep the core carry, R6 hold afterward
    step(1, 12'hABC, 0, 0, 0, 0, 0);
    step(1, 12'hDEF, 1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 1, 8'h5A, 0);
    chk("R5 tbr", tbr_o, 4'h5);
    chk("R5 cy kept", cy_o, 0);
    step(0, 0, 0, 1, 0, 8'hFF, 1);
    chk("R6 acc hold", acc_o, 4'hA);
    step(0, 0, 0, 1, 1, 8'hC3, 1);   // R7 constant return on empty
    idle();

    // R8: push with pop replaces top; and on empty
    step(1, 12'h010, 0, 0, 0, 0, 0);
    step(1, 12'h020, 1, 1, 0, 0, 0);
    chk("R8 returned old top", pc_o, 12'h010);
    step(0, 0, 0, 1, 0, 0, 0);
    chk("R8 replaced top", pc_o, 12'h020);
    step(1, 12'h777, 1, 1, 0, 0, 0);
    chk("R8 empty swap depth", depth_o, 0);

    // Pseudo-random stream
    for (int i = 0; i < 400; i++) begin
      int r = $urandom;
      step(r[0], r[19:8], r[1], r[2] & r[3], r[4], r[27:20], r[5]);
    end

    // R1: reset in mid-run
    rst = 1;
    @(posedge clk); model_edge(); @(negedge clk);
    compare();
    rst = 0;
    idle();

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule